// File: doc/BRIEF.md
# MIDI Channel Message Parser

This block turns a stream of received MIDI bytes into complete channel voice messages. Bytes arrive one at a time, each marked by a one-cycle valid strobe, typically from a serial receiver running at the MIDI bit rate. The parser accepts only the message kinds that carry exactly two data bytes: note off, note on, polyphonic pressure, control change and pitch bend. For each complete message it raises a one-cycle pulse and presents the message kind, the channel and both data bytes.

A status byte has bit 7 set and a data byte has bit 7 clear. The parser waits for a supported status byte and latches it. It then collects a first and a second data byte and presents the message. After a message it waits for a new first data byte under the same latched status. Any supported status byte that arrives restarts collection under the new status and discards the partial message. A status byte of any other kind (high nibble 0xC, 0xD or 0xF) clears the parser back to idle. Data bytes that arrive with no status latched are dropped.

The controller has four states. It starts in IDLE. In IDLE, a supported status moves it to WAIT_FIRST (`go`). In WAIT_FIRST, a data byte moves it to WAIT_SECOND (`first`). In WAIT_SECOND, a data byte moves it to EMIT (`second`). EMIT lasts one cycle: with no byte it moves to WAIT_FIRST (`rearm`), and a data byte moves it straight to WAIT_SECOND (`first`). From any state, a supported status goes to WAIT_FIRST (`resync`) and an unsupported status goes to IDLE (`abort`). A data byte in IDLE leaves the state unchanged (`drop`).

Top module: `midi_msg_parser`

## Requirements
- R1: After a synchronous active-high reset, msg_valid is 0 and msg_type, channel, data1 and data2 are all 0.
- R2: Only a byte with bit 7 set and a high nibble of 0x8, 0x9, 0xA, 0xB or 0xE starts a message. msg_type only ever reports one of these five values.
- R3: After a supported status, the second data byte accepted on clock edge N gives msg_valid high for exactly one cycle, the cycle that follows edge N.
- R4: With msg_valid, msg_type is the high nibble of the latched status and channel is its low nibble. data1 and data2 are the low 7 bits of the two data bytes, in the order they arrived.
- R5: A supported status byte arriving while data are being collected replaces the latched status and discards any first data byte already taken.
- R6: A status byte with high nibble 0xC, 0xD or 0xF discards any partial message and the latched status. Data bytes after it produce no message until a supported status arrives.
- R7: Data bytes received with no status latched (after reset, or after R6) are dropped.
- R8: After a message, the next two data bytes form another message under the same latched status, with no new status byte.
- R9: msg_type, channel, data1 and data2 change only in the cycle in which msg_valid is high. They hold their values otherwise.
- R10: While byte_valid is 0, the value on byte_in has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_in | input | 8 | Received MIDI byte |
| byte_valid | input | 1 | byte_in is valid in this cycle |
| msg_valid | output | 1 | One-cycle pulse: a complete message is presented |
| msg_type | output | 4 | High nibble of the message status |
| channel | output | 4 | Low nibble of the message status |
| data1 | output | 7 | First data byte |
| data2 | output | 7 | Second data byte |

## Verification
Each accepted byte affects the outputs exactly one clock edge later. The second data byte taken at edge N loads the output fields and raises msg_valid in the cycle that follows N. Any status byte taken at edge N forces msg_valid low in that same following cycle. The bench drives inputs on the falling edge. Its reference model absorbs each byte at the rising edge, and it compares every output on the next falling edge, so each expected value is due in exactly the cycle the design produces it.

// File: rtl/midi_parser_pkg.sv
package midi_parser_pkg;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_WAIT_FIRST,
        PS_WAIT_SECOND,
        PS_EMIT
    } parse_state_t;

    // Message kinds carrying two data bytes
    function automatic logic kind_has_two_data(input logic [3:0] kind);
        logic ok;
        unique case (kind)
            4'h8, 4'h9, 4'hA, 4'hB, 4'hE: ok = 1'b1;
            default:                      ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/midi_byte_decode.sv
module midi_byte_decode #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              byte_valid,
    output logic              status_go,
    output logic              status_stop,
    output logic              data_seen
);
    import midi_parser_pkg::*;

    localparam int NIB_W = BYTE_W / 2;

    logic             is_status;
    logic [NIB_W-1:0] kind;

    assign is_status   = byte_valid && byte_in[BYTE_W-1];
    assign kind        = byte_in[BYTE_W-1 -: NIB_W];
    assign status_go   = is_status && kind_has_two_data(kind);
    assign status_stop = is_status && !kind_has_two_data(kind);
    assign data_seen   = byte_valid && !byte_in[BYTE_W-1];

endmodule

// File: rtl/midi_parse_fsm.sv
module midi_parse_fsm (
    input  logic clk,
    input  logic rst,
    input  logic status_go,
    input  logic status_stop,
    input  logic data_seen,
    output logic take_status,
    output logic take_first,
    output logic take_second,
    output logic emit
);
    import midi_parser_pkg::*;

    parse_state_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= PS_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx    = state;
        take_status = 1'b0;
        take_first  = 1'b0;
        take_second = 1'b0;
        emit        = (state == PS_EMIT);
        if (status_go) begin
            take_status = 1'b1;
            state_nx    = PS_WAIT_FIRST;
        end else if (status_stop) begin
            state_nx    = PS_IDLE;
        end else if (data_seen) begin
            unique case (state)
                PS_IDLE: state_nx = PS_IDLE;
                PS_WAIT_FIRST, PS_EMIT: begin
                    take_first = 1'b1;
                    state_nx   = PS_WAIT_SECOND;
                end
                PS_WAIT_SECOND: begin
                    take_second = 1'b1;
                    state_nx    = PS_EMIT;
                end
            endcase
        end else if (state == PS_EMIT) begin
            state_nx = PS_WAIT_FIRST;
        end
    end

endmodule

// File: rtl/midi_msg_regs.sv
module midi_msg_regs #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                take_status,
    input  logic                take_first,
    input  logic                take_second,
    output logic [BYTE_W/2-1:0] msg_type,
    output logic [BYTE_W/2-1:0] channel,
    output logic [BYTE_W-2:0]   data1,
    output logic [BYTE_W-2:0]   data2
);
    localparam int NIB_W  = BYTE_W / 2;
    localparam int DATA_W = BYTE_W - 1;

    logic [BYTE_W-1:0] status_q;
    logic [DATA_W-1:0] first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            first_q  <= '0;
            msg_type <= '0;
            channel  <= '0;
            data1    <= '0;
            data2    <= '0;
        end else begin
            if (take_status) status_q <= byte_in;
            if (take_first)  first_q  <= byte_in[DATA_W-1:0];
            if (take_second) begin
                msg_type <= status_q[BYTE_W-1 -: NIB_W];
                channel  <= status_q[NIB_W-1:0];
                data1    <= first_q;
                data2    <= byte_in[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/midi_msg_parser.sv
module midi_msg_parser #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [BYTE_W-1:0]   byte_in,
    input  logic                byte_valid,
    output logic                msg_valid,
    output logic [BYTE_W/2-1:0] msg_type,
    output logic [BYTE_W/2-1:0] channel,
    output logic [BYTE_W-2:0]   data1,
    output logic [BYTE_W-2:0]   data2
);
    logic status_go, status_stop, data_seen;
    logic take_status, take_first, take_second;

    midi_byte_decode #(.BYTE_W(BYTE_W)) u_dec (
        .byte_in     (byte_in),
        .byte_valid  (byte_valid),
        .status_go   (status_go),
        .status_stop (status_stop),
        .data_seen   (data_seen)
    );

    midi_parse_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .status_go   (status_go),
        .status_stop (status_stop),
        .data_seen   (data_seen),
        .take_status (take_status),
        .take_first  (take_first),
        .take_second (take_second),
        .emit        (msg_valid)
    );

    midi_msg_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .byte_in     (byte_in),
        .take_status (take_status),
        .take_first  (take_first),
        .take_second (take_second),
        .msg_type    (msg_type),
        .channel     (channel),
        .data1       (data1),
        .data2       (data2)
    );

endmodule

// File: rtl/midi_parser_chk.sv
module midi_parser_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [BYTE_W-1:0]   byte_in,
    input logic                byte_valid,
    input logic                msg_valid,
    input logic [BYTE_W/2-1:0] msg_type,
    input logic [BYTE_W/2-1:0] channel,
    input logic [BYTE_W-2:0]   data1,
    input logic [BYTE_W-2:0]   data2
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (!msg_valid && msg_type == '0 && channel == '0 && data1 == '0 && data2 == '0));

    // R2
    kind_legal_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_type inside {4'h8, 4'h9, 4'hA, 4'hB, 4'hE}));

    // R3
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |=> !msg_valid);

    // R3
    pulse_after_data_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> ($past(byte_valid) && !$past(byte_in[BYTE_W-1])));

    // R4
    second_byte_chk: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (data2 == $past(byte_in[BYTE_W-2:0])));

    // R5
    status_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && byte_in[BYTE_W-1]) |=> !msg_valid);

    // R9
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !msg_valid |-> ($stable(msg_type) && $stable(channel) && $stable(data1) && $stable(data2)));

endmodule

bind midi_msg_parser midi_parser_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/sim_midi_msg_parser.sv
module sim_midi_msg_parser;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] byte_in = 8'h00;
    logic       byte_valid = 1'b0;
    logic       msg_valid;
    logic [3:0] msg_type, channel;
    logic [6:0] data1, data2;

    always #2.5 clk = ~clk;

    midi_msg_parser u0 (
        .clk(clk), .rst(rst), .byte_in(byte_in), .byte_valid(byte_valid),
        .msg_valid(msg_valid), .msg_type(msg_type), .channel(channel),
        .data1(data1), .data2(data2)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    string cur_tag  = "R1";

    // reference model state
    bit       m_have, m_got1;
    bit [7:0] m_stat;
    bit [6:0] m_d1;
    bit       e_valid;
    bit [3:0] e_type, e_chan;
    bit [6:0] e_d1, e_d2;
    bit [21:0] msg_q[$];
    int       model_msgs = 0;

    function automatic bit two_data_kind(input bit [3:0] k);
        return (k == 4'h8) || (k == 4'h9) || (k == 4'hA) || (k == 4'hB) || (k == 4'hE);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // model absorbs the byte present at each rising edge
    always @(posedge clk) begin
        e_valid = 1'b0;
        if (rst) begin
            m_have = 0; m_got1 = 0; m_stat = 0; m_d1 = 0;
            e_type = 0; e_chan = 0; e_d1 = 0; e_d2 = 0;
            msg_q.delete();
        end else if (byte_valid) begin
            if (byte_in[7]) begin
                m_got1 = 0;
                if (two_data_kind(byte_in[7:4])) begin m_have = 1; m_stat = byte_in; end
                else m_have = 0;
            end else if (m_have) begin
                if (!m_got1) begin m_d1 = byte_in[6:0]; m_got1 = 1; end
                else begin
                    e_type = m_stat[7:4]; e_chan = m_stat[3:0];
                    e_d1 = m_d1; e_d2 = byte_in[6:0];
                    e_valid = 1'b1; m_got1 = 0;
                    msg_q.push_back({e_type, e_chan, e_d1, e_d2});
                    model_msgs++;
                end
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(msg_valid == e_valid, {cur_tag, "/R3 msg_valid"}, msg_valid, e_valid);
            if (msg_valid) begin
                bit [21:0] got;
                got = {msg_type, channel, data1, data2};
                if (msg_q.size() == 0) check(1'b0, {cur_tag, "/R4 unexpected message"}, got, 0);
                else begin
                    bit [21:0] want;
                    want = msg_q.pop_front();
                    check(got == want, {cur_tag, "/R4 message fields"}, got, want);
                end
            end else begin
                check({msg_type, channel, data1, data2} == {e_type, e_chan, e_d1, e_d2},
                      {cur_tag, "/R9 held fields"},
                      {msg_type, channel, data1, data2}, {e_type, e_chan, e_d1, e_d2});
            end
        end
    end

    // drive a byte for one cycle, then idle cycles with junk on byte_in (R10)
    task automatic send(input bit [7:0] b, input int gap);
        @(negedge clk);
        byte_in = b; byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0; byte_in = 8'h91;
        repeat (gap) begin
            @(negedge clk);
            byte_in = 8'h45;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cur_tag = "R1";
        check({msg_valid, msg_type, channel, data1, data2} == 0, "R1 reset outputs",
              {msg_valid, msg_type, channel, data1, data2}, 0);

        cur_tag = "R7";
        send(8'h12, 0); send(8'h34, 1); send(8'h56, 0);

        cur_tag = "R2";
        send(8'h93, 0); send(8'h3C, 0); send(8'h64, 2);

        cur_tag = "R8";
        send(8'h40, 1); send(8'h00, 1);

        cur_tag = "R5";
        send(8'h80, 0); send(8'h10, 0); send(8'hB5, 0); send(8'h07, 0); send(8'h7F, 1);

        cur_tag = "R6";
        send(8'hA1, 0); send(8'h22, 0); send(8'hC0, 0); send(8'h11, 0); send(8'h22, 1);
        send(8'hE2, 0); send(8'h05, 0); send(8'hF8, 0); send(8'h33, 0); send(8'h44, 1);
        send(8'hD7, 0); send(8'h01, 0); send(8'h02, 1);

        cur_tag = "R10";
        send(8'hE2, 3); send(8'h00, 4); send(8'h40, 3);

        cur_tag = "R4";
        for (int i = 0; i < 1500; i++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 18) send({1'b1, 3'($urandom_range(0, 7)), 4'($urandom_range(0, 15))},
                             $urandom_range(0, 2));
            else        send({1'b0, 7'($urandom_range(0, 127))}, $urandom_range(0, 2));
        end
        repeat (3) @(negedge clk);
        cur_tag = "R3";
        check(msg_q.size() == 0, "R3 messages left undelivered", msg_q.size(), 0);
        check(model_msgs > 20, "R2 enough messages formed", model_msgs, 21);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule